// File: doc/BRIEF.md
# Conditional branch resolver

This block resolves one conditional jump per cycle once the jump has been recognised upstream. It accepts up to six instruction bytes, the address of the first byte and a snapshot of five status flags. From these it works out whether the short form (a one-byte opcode and an 8-bit offset) or the near form (an escape byte, an opcode byte and a 32-bit offset) is present. It then forms the signed offset and evaluates the condition. It produces the fall-through address and the branch target, both measured from the first byte past the jump.

Results are registered: a request presented with `in_valid` high appears on the outputs on the next rising clock edge, with `out_valid` high for that one cycle. The result registers keep their contents until the next request. Instruction fetch, prediction and flag generation belong to neighbouring blocks.

Top module: `cbr_resolve`

## Requirements
- R1: While reset is asserted, and until the first accepted request after reset, `out_valid` is low.
- R2: A request with `in_valid` high at a rising edge gives `out_valid` high exactly one cycle later. `out_valid` is low in any cycle that follows an edge at which `in_valid` was low, and `out_taken`, `out_target` and `out_next` then keep their previous values.
- R3: Byte k of the instruction is carried on `in_bytes[8k+7:8k]`. When byte 0 equals 0x0F, the near form applies: the length is 6, the condition nibble is byte 1 bits 3:0, and the offset is bytes 2..5 taken least significant byte first. Otherwise the short form applies: the length is 2, the condition nibble is byte 0 bits 3:0, and the offset is byte 1.
- R4: `out_next` equals `in_start` plus the length, modulo 2^32.
- R5: `out_target` equals `out_next` plus the offset, sign-extended to 32 bits, modulo 2^32.
- R6: Condition nibble bits 3:1 select the base test: 000 OF, 001 CF, 010 ZF, 011 CF|ZF, 100 SF, 101 PF, 110 SF xor OF, 111 ZF|(SF xor OF).
- R7: Condition nibble bit 0 inverts the base test, so `out_taken` is the base test xor bit 0.
- R8: `in_flags` carries CF on bit 0, ZF on bit 1, SF on bit 2, OF on bit 3 and PF on bit 4.
- R9: In the short form, bytes 2..5 of `in_bytes` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A jump is presented this cycle |
| in_bytes | input | 48 | Instruction bytes, byte 0 in the low eight bits |
| in_start | input | 32 | Address of instruction byte 0 |
| in_flags | input | 5 | Status flag snapshot (CF, ZF, SF, OF, PF from bit 0 up) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_taken | output | 1 | Condition holds |
| out_target | output | 32 | Branch destination |
| out_next | output | 32 | Address just past the jump |

## Verification
The two functions that can fall in the same cycle are the wrap of the target adder past 2^32 and the evaluation of an inverted condition. The bench provokes this with directed near and short jumps placed close to the top and bottom of the address space, with offsets that carry or borrow across the wrap. Each such jump is given a flag pattern that makes the inverted test differ from the plain test. Idle gaps and back-to-back requests are mixed in, so that a register holding its value and a register loading a new value are also judged in neighbouring cycles. A behavioural reference model predicts the strobe and all three results for every cycle, and the bench compares them after each edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int BYTE_W          = 8;
  localparam int OPC_BYTES       = 1;
  localparam int NEAR_DISP_BYTES = 4;
  localparam int SHORT_LEN       = OPC_BYTES + 1;
  localparam int NEAR_LEN        = OPC_BYTES + 1 + NEAR_DISP_BYTES;
  localparam int MAX_LEN         = NEAR_LEN;
  localparam int INSN_W          = MAX_LEN * BYTE_W;
  localparam int LEN_W           = $clog2(MAX_LEN + 1);
  localparam int FLAG_W          = 5;
  localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h0F;

  // bit 0 = carry ... bit 4 = parity
  typedef struct packed {
    logic pf;
    logic of;
    logic sf;
    logic zf;
    logic cf;
  } flags_t;

  typedef enum logic [2:0] {
    SEL_OVF   = 3'b000,
    SEL_CARRY = 3'b001,
    SEL_ZERO  = 3'b010,
    SEL_BEQ   = 3'b011,
    SEL_SIGN  = 3'b100,
    SEL_PAR   = 3'b101,
    SEL_LT    = 3'b110,
    SEL_LE    = 3'b111
  } cond_sel_e;
endpackage

// File: rtl/cbr_form_decode.sv
// Splits the instruction bytes into condition nibble, length and offset (R3, R9).
module cbr_form_decode
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output logic [3:0]        cc,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] disp
);
  logic                                is_near;
  logic [NEAR_DISP_BYTES*BYTE_W-1:0]   near_raw;
  logic [BYTE_W-1:0]                   short_raw;

  // near offset bytes follow the escape and opcode bytes, low byte first
  for (genvar g = 0; g < NEAR_DISP_BYTES; g++) begin : g_disp
    assign near_raw[g*BYTE_W +: BYTE_W] = insn[(OPC_BYTES + 1 + g)*BYTE_W +: BYTE_W];
  end

  assign short_raw = insn[OPC_BYTES*BYTE_W +: BYTE_W];

  always_comb begin
    is_near = (insn[BYTE_W-1:0] == ESC_BYTE);
    if (is_near) begin
      cc   = insn[BYTE_W +: 4];
      len  = LEN_W'(NEAR_LEN);
      disp = ADDR_W'($signed(near_raw));
    end else begin
      cc   = insn[3:0];
      len  = LEN_W'(SHORT_LEN);
      disp = ADDR_W'($signed(short_raw));
    end
  end
endmodule

// File: rtl/cbr_cond_eval.sv
// Selects the base flag test and applies the inversion bit (R6, R7, R8).
module cbr_cond_eval
  import cbr_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] cc,
  output logic       taken
);
  cond_sel_e sel;
  logic      base;
  logic      lt;

  always_comb begin
    sel = cond_sel_e'(cc[3:1]);
    lt  = flags.sf ^ flags.of;
    unique case (sel)
      SEL_OVF:   base = flags.of;
      SEL_CARRY: base = flags.cf;
      SEL_ZERO:  base = flags.zf;
      SEL_BEQ:   base = flags.cf | flags.zf;
      SEL_SIGN:  base = flags.sf;
      SEL_PAR:   base = flags.pf;
      SEL_LT:    base = lt;
      SEL_LE:    base = flags.zf | lt;
      default:   base = 1'b0;
    endcase
    taken = base ^ cc[0];
  end
endmodule

// File: rtl/cbr_addr_calc.sv
// Fall-through and target adders, both wrapping at the address width (R4, R5).
module cbr_addr_calc
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] target
);
  always_comb begin
    next_addr = start + ADDR_W'(len);
    target    = next_addr + disp;
  end
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_bytes,
  input  logic [ADDR_W-1:0] in_start,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [ADDR_W-1:0] out_next
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[SYNC_STAGES-1];

  // combinational resolve path
  logic [3:0]        cc_c;
  logic [LEN_W-1:0]  len_c;
  logic [ADDR_W-1:0] disp_c;
  logic [ADDR_W-1:0] next_c;
  logic [ADDR_W-1:0] target_c;
  logic              taken_c;
  flags_t            flags_c;

  assign flags_c = flags_t'(in_flags);

  cbr_form_decode #(.ADDR_W(ADDR_W)) dec_i (
    .insn (in_bytes),
    .cc   (cc_c),
    .len  (len_c),
    .disp (disp_c)
  );

  cbr_cond_eval cond_i (
    .flags (flags_c),
    .cc    (cc_c),
    .taken (taken_c)
  );

  cbr_addr_calc #(.ADDR_W(ADDR_W)) addr_i (
    .start     (in_start),
    .len       (len_c),
    .disp      (disp_c),
    .next_addr (next_c),
    .target    (target_c)
  );

  // next-state
  logic              load_en;
  logic              valid_d;
  logic              taken_d;
  logic [ADDR_W-1:0] target_d;
  logic [ADDR_W-1:0] next_d;

  always_comb begin
    load_en  = in_valid;
    valid_d  = in_valid;
    taken_d  = taken_c;
    target_d = target_c;
    next_d   = next_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) out_valid <= 1'b0;
    else             out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      out_taken  <= taken_d;
      out_target <= target_d;
      out_next   <= next_d;
    end
  end
endmodule

// File: rtl/cbr_resolve_checker.sv
module cbr_resolve_checker
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_bytes,
  input logic [ADDR_W-1:0] in_start,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_target,
  input logic [ADDR_W-1:0] out_next
);
  a_r2_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_taken) && $stable(out_target) && $stable(out_next)));

  a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_next == $past(in_start) +
      (($past(in_bytes[7:0]) == ESC_BYTE) ? ADDR_W'(NEAR_LEN) : ADDR_W'(SHORT_LEN)));

  a_r5_short_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bytes[7:0] != ESC_BYTE) |=>
      (out_target - out_next) == ADDR_W'($signed($past(in_bytes[15:8]))));

  a_r6_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bytes[7:0] == 8'h74) |=> out_taken == $past(in_flags[1]));

  a_r7_zero_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bytes[7:0] == 8'h75) |=> out_taken != $past(in_flags[1]));
endmodule

bind cbr_resolve cbr_resolve_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .in_valid   (in_valid),
  .in_bytes   (in_bytes),
  .in_start   (in_start),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_taken  (out_taken),
  .out_target (out_target),
  .out_next   (out_next)
);

// File: tb/cbr_resolve_tb.sv
module cbr_resolve_tb_top;
  localparam time HALF = 10ns;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [47:0] in_bytes;
  logic [31:0] in_start;
  logic [4:0]  in_flags;
  logic        out_valid;
  logic        out_taken;
  logic [31:0] out_target;
  logic [31:0] out_next;

  always #HALF clk = ~clk;

  cbr_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_start(in_start), .in_flags(in_flags), .out_valid(out_valid),
    .out_taken(out_taken), .out_target(out_target), .out_next(out_next)
  );

  typedef struct {
    bit        v;
    bit        has_data;
    bit        tk;
    bit [31:0] nx;
    bit [31:0] tg;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // behavioural reference for one jump (R3..R9)
  function automatic exp_t ref_calc(bit [47:0] b, bit [31:0] st, bit [4:0] fl);
    exp_t e;
    bit       near;
    bit [7:0] op;
    int       len;
    int       d;
    bit c, z, s, o, p, r;
    near = (b[7:0] == 8'h0F);
    op   = near ? b[15:8] : b[7:0];
    len  = near ? 6 : 2;
    if (near) d = int'(b[47:16]);
    else      d = int'($signed(b[15:8]));
    c = fl[0]; z = fl[1]; s = fl[2]; o = fl[3]; p = fl[4];
    case (op[3:1])
      3'd0: r = o;
      3'd1: r = c;
      3'd2: r = z;
      3'd3: r = c | z;
      3'd4: r = s;
      3'd5: r = p;
      3'd6: r = (s != o);
      default: r = z | (s != o);
    endcase
    e.v = 1; e.has_data = 1;
    e.tk = r ^ op[0];
    e.nx = st + 32'(len);
    e.tg = st + 32'(len) + 32'(d);
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // one clock: compare the outputs of the previous edge, then drive new inputs
  task automatic step(bit v, bit [47:0] b, bit [31:0] st, bit [4:0] fl);
    exp_t e, n;
    @(negedge clk);
    e = q.pop_front();
    chk(out_valid == e.v, "R1 R2", "out_valid", out_valid, e.v);
    if (e.has_data) begin
      chk(out_taken == e.tk, "R6 R7 R8", "out_taken", out_taken, e.tk);
      chk(out_next == e.nx, "R3 R4", "out_next", out_next, e.nx);
      chk(out_target == e.tg, "R3 R5 R9", "out_target", out_target, e.tg);
    end
    in_valid = v; in_bytes = b; in_start = st; in_flags = fl;
    if (v) begin
      n = ref_calc(b, st, fl);
      last = n;
    end else begin
      n = last;
      n.v = 0;
    end
    q.push_back(n);
  endtask

  function automatic bit [47:0] mk_short(bit [3:0] cc, bit [7:0] d, bit [31:0] junk);
    return {junk, d, 4'h7, cc};
  endfunction

  function automatic bit [47:0] mk_near(bit [3:0] cc, bit [31:0] d);
    return {d, 4'h8, cc, 8'h0F};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t z0;
    z0.v = 0; z0.has_data = 0; z0.tk = 0; z0.nx = 0; z0.tg = 0;
    last = z0;
    q.push_back(z0);
    rst_n = 0; in_valid = 0; in_bytes = '0; in_start = '0; in_flags = '0;
    // R1: strobe low through reset
    repeat (3) step(0, '0, '0, '0);
    @(negedge clk); rst_n = 1;
    // R1: strobe low after release, before any request
    repeat (4) step(0, '0, '0, '0);

    // R6 R7 R8: every condition nibble against every flag pattern, short form
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 32; f++)
        step(1, mk_short(4'(cc), 8'(f * 7), 32'hDEAD_0000 + 32'(f)), 32'h0040_1000 + 32'(f), 5'(f));

    // R3 R5: near form, every nibble, positive and negative offsets
    for (int cc = 0; cc < 16; cc++) begin
      step(1, mk_near(4'(cc), 32'h0000_101E), 32'h0040_2000, 5'(cc * 3));
      step(1, mk_near(4'(cc), 32'hFFFF_FF00), 32'h0040_2000, 5'(cc * 5));
    end

    // R4 R5 R7: wrap near the top and bottom of the space, inverted tests
    step(1, mk_near(4'h5, 32'h0000_0020), 32'hFFFF_FFF0, 5'b00010); // ZF=1, jnz not taken
    step(1, mk_near(4'h4, 32'h0000_0020), 32'hFFFF_FFFC, 5'b00010);
    step(1, mk_short(4'h3, 8'h80, 32'h0), 32'h0000_0004, 5'b00001); // borrow below zero
    step(0, '0, '0, '0);
    step(1, mk_short(4'hF, 8'h7F, 32'hFFFF_FFFF), 32'hFFFF_FF90, 5'b00100);
    step(1, mk_near(4'hE, 32'h8000_0000), 32'h7FFF_FFFA, 5'b01100);

    // R2: idle gaps hold the results
    step(1, mk_short(4'h2, 8'h10, 32'h0), 32'h1000, 5'b00010);
    repeat (3) step(0, mk_short(4'h3, 8'h55, 32'h0), 32'hABCD, 5'b11111);

    // R9: identical short jumps with different trailing bytes
    step(1, mk_short(4'h6, 8'hF0, 32'h0000_0000), 32'h2222_0000, 5'b01000);
    step(1, mk_short(4'h6, 8'hF0, 32'hFFFF_FFFF), 32'h2222_0000, 5'b01000);
    step(1, mk_short(4'h6, 8'hF0, 32'h0F0F_0F0F), 32'h2222_0000, 5'b01000);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit        v;
      bit [47:0] b;
      v = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 1) == 1) b = mk_near(4'($urandom), $urandom);
      else                           b = mk_short(4'($urandom), 8'($urandom), $urandom);
      step(v, b, $urandom, 5'($urandom));
    end

    step(0, '0, '0, '0);
    step(0, '0, '0, '0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule